// File: doc/BRIEF.md
# Range-Test and Rule-Bit Coprocessor

This block speeds up the inner loop of bit-vector table construction for a packet classifier. For every point of a byte-wide lookup table, the host has to decide whether that point lies in the range of one rule field and, if it does, set the rule's bit in the group vector. Here the host loads a lower bound, an upper bound, an alignment shift and a test point through a small register bus. It then reads back a word that already holds the rule's one-hot bit when the point matches and holds zero when it does not. Because a miss returns zero, the host can OR the word into its vector without a branch.

Before the comparison, both bounds are shifted right by the alignment amount. This brings the byte chunk of interest down to the low end of the word. When the shifted low bound is not below the shifted high bound, the test is reversed: the point matches only when it lies strictly between the two values. The same bus also gives direct access to a decoder that turns a rule number into a one-hot word. That path needs one write and one read.

Top module: `rngbit_top`

## Requirements
- R1: After reset, reading the result address (0) returns 0, reading the one-hot address (1) returns 1 (rule 0), and reading the status address (2) returns 0.
- R2: Write address 2 loads the alignment shift from write-data bits [4:0]. Both bounds are shifted right by this amount before comparison. The test point is never shifted.
- R3: When the shifted low bound (write address 0) is below the shifted high bound (write address 1), a test point (write address 3) matches exactly when low <= point <= high, with both ends inclusive.
- R4: When the shifted low bound is above the shifted high bound, the point matches exactly when high < point < low, with both ends exclusive.
- R5: When the shifted bounds are equal, no point matches.
- R6: A read of address 0 returns the one-hot word of the stored rule number when the point matches, and all zeros when it does not.
- R7: Write address 4 loads the rule number. A read of address 1 returns 1 shifted left by the rule number modulo 32 (write-data bits [4:0]).
- R8: Bit 0 of the status word (read address 2) is 1 exactly when each of write addresses 0, 1, 2 and 3 has been written since the last read of address 0. All other status bits are 0.
- R9: A read of address 0 clears the written-operand record from the next cycle on. A write made in the same cycle as that read still counts toward the next sequence.
- R10: Writes to addresses 5 to 7 change nothing. Reads of addresses 3 to 7, and any cycle with the read enable low, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 3 | Write register address |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe; a read of address 0 also clears the sequence |
| rdAddr | input | 3 | Read register address |
| rdData | output | 32 | Read data, valid in the same cycle as rdEn |

## Verification
The assertions take for granted that the bus inputs are never unknown while out of reset, and that the alignment shift only uses its five low bits. The comparison properties also assume the registers change only on their own write strobes, so that a match seen in one cycle reflects the operands held in that cycle. The stimulus changes inputs only just after a rising edge, and it writes one register per cycle. It covers ordered, inverted and equal bounds, both ends of each interval, unused addresses, and a result read in the same cycle as a write.

// File: rtl/rngbit_pkg.sv
package rngbit_pkg;

  localparam int unsigned ADR_LO   = 0;
  localparam int unsigned ADR_HI   = 1;
  localparam int unsigned ADR_SH   = 2;
  localparam int unsigned ADR_PT   = 3;
  localparam int unsigned ADR_RULE = 4;

  localparam int unsigned RADR_RES  = 0;
  localparam int unsigned RADR_HOT  = 1;
  localparam int unsigned RADR_STAT = 2;

  typedef struct packed {
    logic ldLo;
    logic ldHi;
    logic ldSh;
    logic ldPt;
    logic ldRule;
  } ldStrobe_t;

  typedef enum logic [1:0] {
    SEL_ZERO,
    SEL_RANGE,
    SEL_ONEHOT,
    SEL_STATUS
  } rdSel_t;

endpackage

// File: rtl/rngbit_ctrl.sv
module rngbit_ctrl
  import rngbit_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output ldStrobe_t         ld,
  output rdSel_t            rdSel,
  output logic              opsReady
);

  localparam int unsigned NUM_OPS = 4;

  logic [NUM_OPS-1:0] seenOps;
  logic [NUM_OPS-1:0] wrHits;
  logic               clrSeq;

  always_comb begin
    ld        = '0;
    ld.ldLo   = wrEn && (wrAddr == ADDR_W'(ADR_LO));
    ld.ldHi   = wrEn && (wrAddr == ADDR_W'(ADR_HI));
    ld.ldSh   = wrEn && (wrAddr == ADDR_W'(ADR_SH));
    ld.ldPt   = wrEn && (wrAddr == ADDR_W'(ADR_PT));
    ld.ldRule = wrEn && (wrAddr == ADDR_W'(ADR_RULE));
  end

  assign wrHits = {ld.ldPt, ld.ldSh, ld.ldHi, ld.ldLo};
  assign clrSeq = rdEn && (rdAddr == ADDR_W'(RADR_RES));

  always_ff @(posedge clk) begin
    if (!rstN) seenOps <= '0;
    else       seenOps <= (clrSeq ? '0 : seenOps) | wrHits;
  end

  assign opsReady = &seenOps;

  always_comb begin
    rdSel = SEL_ZERO;
    if (rdEn) begin
      if (rdAddr == ADDR_W'(RADR_RES))       rdSel = SEL_RANGE;
      else if (rdAddr == ADDR_W'(RADR_HOT))  rdSel = SEL_ONEHOT;
      else if (rdAddr == ADDR_W'(RADR_STAT)) rdSel = SEL_STATUS;
    end
  end

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == ADDR_W'(RADR_RES) && !wrEn) |=> !opsReady); // R9
  AST_READY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(opsReady) |-> $past(wrEn)); // R8
  AST_HIGH_ADDR_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr > ADDR_W'(ADR_RULE)) |-> (ld == '0)); // R10

endmodule

// File: rtl/rngbit_dp.sv
module rngbit_dp
  import rngbit_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned VEC_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ldStrobe_t         ld,
  input  logic [DATA_W-1:0] wrData,
  input  rdSel_t            rdSel,
  input  logic              opsReady,
  output logic [DATA_W-1:0] rdData
);

  localparam int unsigned SH_W  = $clog2(DATA_W);
  localparam int unsigned IDX_W = $clog2(VEC_W);

  logic [DATA_W-1:0] loBound, hiBound, testPt;
  logic [SH_W-1:0]   shAmt;
  logic [IDX_W-1:0]  ruleIdx;

  logic [DATA_W-1:0] loS, hiS;
  logic              ordered, geLo, leHi, match;
  logic [VEC_W-1:0]  oneHot, rangeWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loBound <= '0;
      hiBound <= '0;
      testPt  <= '0;
      shAmt   <= '0;
      ruleIdx <= '0;
    end else begin
      if (ld.ldLo)   loBound <= wrData;
      if (ld.ldHi)   hiBound <= wrData;
      if (ld.ldSh)   shAmt   <= wrData[SH_W-1:0];
      if (ld.ldPt)   testPt  <= wrData;
      if (ld.ldRule) ruleIdx <= wrData[IDX_W-1:0];
    end
  end

  assign loS     = loBound >> shAmt;
  assign hiS     = hiBound >> shAmt;
  assign ordered = loS < hiS;
  assign geLo    = testPt >= loS;
  assign leHi    = testPt <= hiS;
  assign match   = ~(geLo ^ ordered) & ~(leHi ^ ordered);

  for (genvar b = 0; b < VEC_W; b++) begin : g_dec
    assign oneHot[b] = (ruleIdx == IDX_W'(b));
  end

  assign rangeWord = match ? oneHot : '0;

  always_comb begin
    unique case (rdSel)
      SEL_RANGE:  rdData = DATA_W'(rangeWord);
      SEL_ONEHOT: rdData = DATA_W'(oneHot);
      SEL_STATUS: rdData = DATA_W'(opsReady);
      default:    rdData = '0;
    endcase
  end

  AST_EQUAL_BOUNDS_NO_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (loS == hiS) |-> !match); // R5
  AST_ORDERED_INSIDE: assert property (@(posedge clk) disable iff (!rstN)
    (loS < hiS && match) |-> (testPt >= loS && testPt <= hiS)); // R3
  AST_INVERTED_BETWEEN: assert property (@(posedge clk) disable iff (!rstN)
    (loS > hiS && match) |-> (testPt < loS && testPt > hiS)); // R4
  AST_RESULT_WITHIN_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    ((rangeWord & ~oneHot) == '0) && ($countones(rangeWord) <= 1)); // R6
  AST_RULE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !ld.ldRule |=> $stable(ruleIdx)); // R7

endmodule

// File: rtl/rngbit_top.sv
module rngbit_top
  import rngbit_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned VEC_W  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  ldStrobe_t ld;
  rdSel_t    rdSel;
  logic      opsReady;

  rngbit_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .rdEn(rdEn), .rdAddr(rdAddr), .ld(ld), .rdSel(rdSel), .opsReady(opsReady)
  );

  rngbit_dp #(.DATA_W(DATA_W), .VEC_W(VEC_W)) dp_i (
    .clk(clk), .rstN(rstN), .ld(ld), .wrData(wrData),
    .rdSel(rdSel), .opsReady(opsReady), .rdData(rdData)
  );

endmodule

// File: tb/rngbit_tb_top.sv
`timescale 1ns/1ps
module rngbit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  rngbit_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  // behavioural reference state
  longint unsigned mLo, mHi, mPt;
  int              mSh, mRule;
  bit              mSeen[4];

  always @(posedge clk) begin
    if (!rstN) begin
      mLo = 0; mHi = 0; mPt = 0; mSh = 0; mRule = 0;
      foreach (mSeen[i]) mSeen[i] = 0;
    end else begin
      if (rdEn && rdAddr == 0) foreach (mSeen[i]) mSeen[i] = 0;
      if (wrEn) begin
        case (wrAddr)
          3'd0: begin mLo = wrData; mSeen[0] = 1; end
          3'd1: begin mHi = wrData; mSeen[1] = 1; end
          3'd2: begin mSh = wrData % 32; mSeen[2] = 1; end
          3'd3: begin mPt = wrData; mSeen[3] = 1; end
          3'd4: mRule = wrData % 32;
          default: ;
        endcase
      end
    end
  end

  function automatic longint unsigned modelRead(bit en, int adr);
    longint unsigned lo, hi, hot;
    bit hit;
    if (!en) return 0;
    lo  = mLo / (longint'(1) << mSh);
    hi  = mHi / (longint'(1) << mSh);
    hot = longint'(1) << mRule;
    if (lo < hi)      hit = (mPt >= lo) && (mPt <= hi);
    else if (lo > hi) hit = (mPt > hi) && (mPt < lo);
    else              hit = 0;
    case (adr)
      0: return hit ? hot : 0;
      1: return hot;
      2: return (mSeen[0] && mSeen[1] && mSeen[2] && mSeen[3]) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      string tag;
      case (rdAddr)
        3'd0: tag = "R6 model";
        3'd1: tag = "R7 model";
        3'd2: tag = "R8 model";
        default: tag = "R10 model";
      endcase
      check(tag, longint'(rdData), modelRead(rdEn, int'(rdAddr)));
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    wrEn = 0; rdEn = 0;
  endtask

  task automatic wr(int adr, logic [31:0] d);
    @(posedge clk); #1;
    rdEn = 0; wrEn = 1; wrAddr = 3'(adr); wrData = d;
  endtask

  task automatic rdExpect(int adr, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    wrEn = 0; rdEn = 1; rdAddr = 3'(adr);
    @(negedge clk); #1;
    check(tag, longint'(rdData), longint'(exp));
  endtask

  task automatic loadAll(logic [31:0] lo, logic [31:0] hi, int sh, logic [31:0] pt);
    wr(0, lo); wr(1, hi); wr(2, 32'(sh)); wr(3, pt);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    rdExpect(0, 32'h0, "R1 result after reset");
    rdExpect(1, 32'h1, "R1 one-hot after reset");
    rdExpect(2, 32'h0, "R1 status after reset");

    wr(4, 32'd5);
    rdExpect(1, 32'h20, "R7 rule 5");
    wr(4, 32'd35);
    rdExpect(1, 32'h8, "R7 rule 35 wraps to 3");

    loadAll(32'h1000, 32'h3000, 8, 32'h10);
    rdExpect(2, 32'h1, "R8 four operands written");
    rdExpect(0, 32'h8, "R3 low edge inclusive");
    rdExpect(2, 32'h0, "R9 status cleared by read");
    wr(3, 32'h30);
    rdExpect(0, 32'h8, "R3 high edge inclusive");
    wr(3, 32'h31);
    rdExpect(0, 32'h0, "R6 miss above high returns zero");
    wr(3, 32'h0F);
    rdExpect(0, 32'h0, "R3 below low");
    wr(3, 32'h1000);
    rdExpect(0, 32'h0, "R2 point not shifted");

    loadAll(32'h50, 32'h20, 0, 32'h30);
    rdExpect(0, 32'h8, "R4 inverted between");
    wr(3, 32'h50);
    rdExpect(0, 32'h0, "R4 inverted low edge excluded");
    wr(3, 32'h20);
    rdExpect(0, 32'h0, "R4 inverted high edge excluded");
    wr(3, 32'h10);
    rdExpect(0, 32'h0, "R4 inverted outside");
    loadAll(32'h5000, 32'h2000, 8, 32'h21);
    rdExpect(0, 32'h8, "R2 inverted after shift");

    loadAll(32'h40, 32'h40, 0, 32'h40);
    rdExpect(0, 32'h0, "R5 equal bounds");

    wr(0, 32'h0); wr(1, 32'hFF); wr(3, 32'h7);
    rdExpect(2, 32'h0, "R8 shift not written");
    wr(2, 32'd0);
    rdExpect(2, 32'h1, "R8 all written");

    wr(6, 32'hFFFF_FFFF); wr(5, 32'd1); wr(7, 32'h0);
    rdExpect(1, 32'h8, "R10 rule unchanged");
    rdExpect(0, 32'h8, "R10 bounds unchanged");
    rdExpect(5, 32'h0, "R10 unused read address");

    wr(4, 32'd31);
    @(posedge clk); #1;
    rdEn = 1; rdAddr = 3'd0; wrEn = 1; wrAddr = 3'd0; wrData = 32'h0;
    @(posedge clk); #1;
    wrEn = 0; rdEn = 0;
    wr(1, 32'hFF); wr(2, 32'd0); wr(3, 32'h9);
    rdExpect(2, 32'h1, "R9 same-cycle write counted");
    rdExpect(0, 32'h8000_0000, "R6 rule 31 match");
    idle();
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule